// File: doc/BRIEF.md
# Transactional Undo-Log Memory Bank

This block is a single word-addressed memory bank that lets several cores run speculative transactions against it. Each core owns a private, fixed-size undo log inside the bank. While a core has a transaction open, the first write it makes to any word first copies that word's current contents into the core's log. Later writes to the same word inside the same transaction are not logged again, so the log only grows with the number of distinct words touched.

A commit strobe drops the core's log and leaves the new data in place. An abort strobe closes the transaction and makes the bank walk that core's log from newest to oldest entry, one entry per cycle, writing every saved word back. The walk runs inside the bank with no handshake to anything outside it. While any walk is pending or running, the bank stalls every request. If a core's log is full and the core tries to write a word it has not yet logged, the bank refuses the write and raises that core's overflow flag. From then on it refuses every write from that core until the core aborts.

Access is through one shared request port: a valid, write, core index, address and write data, with a same-cycle grant and read data one cycle later. Each core has its own begin, commit and abort strobes and its own active, busy and overflow outputs.

Top module: `ubank_top`

## Requirements
- R1: After reset no transaction is open, no core is busy, no overflow flag is set, every word reads as zero, and a read request is granted.
- R2: A write from a core with no open transaction updates the word at once and is never logged, so a later abort by that core restores nothing and holds busy low.
- R3: Inside a transaction only the first write to an address adds a log entry. The log of a core holds at most LOG_DEPTH entries, one per distinct address.
- R4: A commit from a core with an open, non-overflowed transaction closes it, empties its log and keeps the written data. A commit or abort from a core with no open transaction does nothing.
- R5: An abort from a core holding N > 0 log entries restores every logged word to its value from before the transaction. busy[core] is high for exactly N+1 cycles, starting in the cycle after the abort strobe. With N = 0, busy stays low.
- R6: While any busy bit is high, no request is granted. A request from a core whose abort strobe is high in the same cycle is not granted.
- R7: A first write to a new address from a core whose log is full is refused (grant low) and sets logOverflow[core] from the next cycle. While the flag is set, every write from that core is refused, its reads are granted, and its commit is ignored. Its abort clears the flag and restores the log.
- R8: When commit and abort of a core arrive in the same cycle, abort wins. A begin for a core whose transaction is already open is ignored and leaves its log intact.
- R9: A granted read returns the addressed word on rdData in the cycle after the grant.
- R10: Logs of different cores are independent. When several cores abort in the same cycle, their logs are restored one after another, lowest core index first. A core waiting behind an N0-entry walk stays busy for N0+N1+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCore | input | CORE_W | Index of the requesting core |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqGrant | output | 1 | Request accepted this cycle |
| rdData | output | DATA_W | Read data, valid the cycle after a granted read |
| txBegin | input | NUM_CORES | Per-core transaction begin strobe |
| txCommit | input | NUM_CORES | Per-core commit strobe |
| txAbort | input | NUM_CORES | Per-core abort strobe |
| txActive | output | NUM_CORES | Per-core transaction open |
| busy | output | NUM_CORES | Per-core restore pending or in progress |
| logOverflow | output | NUM_CORES | Per-core log overflow flag |

## Verification
The assertions check on every cycle that nothing is granted while a restore is pending, that an overflowed core never gets a write through, that log counts only step up by one or drop to zero, and that a commit empties its log. They also check that the restore walk stays inside the log of a pending core, and that the request path and the restore path never write the array in the same cycle. Only the bench's scenarios can show that restored words carry their pre-transaction values, that repeated writes add no entry, that the busy window has the exact length, and that simultaneous aborts are served lowest core first. A reference model in the bench, driven by mixed random and directed traffic, provides these expected values.

// File: rtl/ubank_pkg.sv
package ubank_pkg;

  // Strobes from the control to the datapath, one cycle each.
  typedef struct packed {
    logic arrWrReq;   // write request data into the array
    logic arrWrLog;   // write a saved log entry back into the array
    logic logSave;    // copy the old word into the selected log slot
    logic rdLatch;    // capture the addressed word on rdData
  } strobe_t;

endpackage

// File: rtl/ubank_ctrl.sv
module ubank_ctrl #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 4,
  parameter int LOG_DEPTH = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SLOT_W   = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1,
  localparam int CNT_W    = $clog2(LOG_DEPTH + 1),
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [NUM_CORES-1:0] txBegin,
  input  logic [NUM_CORES-1:0] txCommit,
  input  logic [NUM_CORES-1:0] txAbort,
  output logic                 reqGrant,
  output logic [NUM_CORES-1:0] txActive,
  output logic [NUM_CORES-1:0] busy,
  output logic [NUM_CORES-1:0] logOverflow,
  output ubank_pkg::strobe_t   strobe,
  output logic [CORE_W-1:0]    logCore,
  output logic [SLOT_W-1:0]    logSlot
);

  // Per-core transaction state
  logic [NUM_CORES-1:0] txOpen;
  logic [NUM_CORES-1:0] ovf;
  logic [NUM_CORES-1:0] pendRestore;
  logic [CNT_W-1:0]     logCnt [NUM_CORES];
  logic [DEPTH-1:0]     wrMap  [NUM_CORES];

  // Restore walker
  logic                 rstActive;
  logic [CORE_W-1:0]    rstCore;
  logic [SLOT_W-1:0]    rstIdx;
  logic [CORE_W-1:0]    nextCore;

  // Request decode
  logic anyRestore, curOpen, curOvf, curHit, curFull;
  logic refuse, canServe, grantInt, ovfTrip, doLog;
  logic [CNT_W-1:0] curCnt;

  always_comb begin
    anyRestore = |pendRestore;
    curOpen    = txOpen[reqCore];
    curOvf     = ovf[reqCore];
    curCnt     = logCnt[reqCore];
    curHit     = wrMap[reqCore][reqAddr];
    curFull    = (curCnt == CNT_W'(LOG_DEPTH));
    refuse     = reqWrite && curOpen && (curOvf || (!curHit && curFull));
    canServe   = reqValid && !anyRestore && !txAbort[reqCore];
    grantInt   = canServe && !refuse;
    ovfTrip    = canServe && refuse && !curOvf;
    doLog      = grantInt && reqWrite && curOpen && !curHit;
  end

  // Lowest-index pending core goes first
  always_comb begin
    nextCore = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (pendRestore[c]) nextCore = CORE_W'(c);
    end
  end

  always_comb begin
    strobe.arrWrReq = grantInt && reqWrite;
    strobe.arrWrLog = rstActive;
    strobe.logSave  = doLog;
    strobe.rdLatch  = grantInt && !reqWrite;
    logCore         = rstActive ? rstCore : reqCore;
    logSlot         = rstActive ? rstIdx  : curCnt[SLOT_W-1:0];
  end

  // Per-core state updates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txOpen      <= '0;
      ovf         <= '0;
      pendRestore <= '0;
      for (int c = 0; c < NUM_CORES; c++) begin
        logCnt[c] <= '0;
        wrMap[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CORES; c++) begin
        logic isMe, doAbort, doCommit, doBegin;
        isMe     = (reqCore == CORE_W'(c));
        doAbort  = txAbort[c] && txOpen[c] && !pendRestore[c];
        doCommit = txCommit[c] && txOpen[c] && !ovf[c] && !txAbort[c];
        doBegin  = txBegin[c] && !txOpen[c] && !pendRestore[c];

        if (doLog && isMe) begin
          wrMap[c][reqAddr] <= 1'b1;
          logCnt[c]         <= logCnt[c] + CNT_W'(1);
        end
        if (ovfTrip && isMe) ovf[c] <= 1'b1;

        if (doAbort) begin
          txOpen[c] <= 1'b0;
          ovf[c]    <= 1'b0;
          if (logCnt[c] == '0) wrMap[c] <= '0;
          else                 pendRestore[c] <= 1'b1;
        end else if (doCommit) begin
          txOpen[c] <= 1'b0;
          logCnt[c] <= '0;
          wrMap[c]  <= '0;
        end else if (doBegin) begin
          txOpen[c] <= 1'b1;
        end

        if (rstActive && (rstCore == CORE_W'(c)) && (rstIdx == '0)) begin
          pendRestore[c] <= 1'b0;
          logCnt[c]      <= '0;
          wrMap[c]       <= '0;
        end
      end
    end
  end

  // Restore walker: one log entry per cycle, newest first
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rstActive <= 1'b0;
      rstCore   <= '0;
      rstIdx    <= '0;
    end else if (!rstActive) begin
      if (anyRestore) begin
        rstActive <= 1'b1;
        rstCore   <= nextCore;
        rstIdx    <= SLOT_W'(logCnt[nextCore] - CNT_W'(1));
      end
    end else if (rstIdx == '0) begin
      rstActive <= 1'b0;
    end else begin
      rstIdx <= rstIdx - SLOT_W'(1);
    end
  end

  assign reqGrant    = grantInt;
  assign txActive    = txOpen;
  assign busy        = pendRestore;
  assign logOverflow = ovf;

  // Checks
  assert_grant_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|busy) |-> !reqGrant);

  assert_ovf_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqWrite && logOverflow[reqCore]) |-> !reqGrant);

  assert_restore_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rstActive |-> (pendRestore[rstCore] && (CNT_W'(rstIdx) < logCnt[rstCore])));

  for (genvar g = 0; g < NUM_CORES; g++) begin : gCoreChk
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      logCnt[g] <= CNT_W'(LOG_DEPTH));

    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (logCnt[g] != $past(logCnt[g])) |->
        ((logCnt[g] == $past(logCnt[g]) + CNT_W'(1)) || (logCnt[g] == '0)));

    assert_commit_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (txCommit[g] && txOpen[g] && !ovf[g] && !txAbort[g]) |=>
        ((logCnt[g] == '0) && !txOpen[g]));

    assert_busy_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy[g] |-> !txActive[g]);
  end

endmodule

// File: rtl/ubank_dp.sv
module ubank_dp #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int LOG_DEPTH = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SLOT_W   = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ubank_pkg::strobe_t strobe,
  input  logic [CORE_W-1:0]  logCore,
  input  logic [SLOT_W-1:0]  logSlot,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic [DATA_W-1:0]  rdData
);

  logic [DATA_W-1:0] mem     [DEPTH];
  logic [ADDR_W-1:0] logAddr [NUM_CORES][LOG_DEPTH];
  logic [DATA_W-1:0] logData [NUM_CORES][LOG_DEPTH];

  logic [ADDR_W-1:0] undoAddr;
  logic [DATA_W-1:0] undoData;

  always_comb begin
    undoAddr = logAddr[logCore][logSlot];
    undoData = logData[logCore][logSlot];
  end

  // Word array and read register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdData <= '0;
    end else begin
      if (strobe.arrWrReq)      mem[reqAddr]  <= reqWdata;
      else if (strobe.arrWrLog) mem[undoAddr] <= undoData;
      if (strobe.rdLatch)       rdData <= mem[reqAddr];
    end
  end

  // Undo log storage, needs no reset: entries are only read below the count
  always_ff @(posedge clk) begin
    if (strobe.logSave) begin
      logAddr[logCore][logSlot] <= reqAddr;
      logData[logCore][logSlot] <= mem[reqAddr];
    end
  end

  assert_one_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.arrWrReq && strobe.arrWrLog));

  assert_save_not_undo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.logSave && strobe.arrWrLog));

endmodule

// File: rtl/ubank_top.sv
module ubank_top #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int LOG_DEPTH = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SLOT_W   = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 reqGrant,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_CORES-1:0] txBegin,
  input  logic [NUM_CORES-1:0] txCommit,
  input  logic [NUM_CORES-1:0] txAbort,
  output logic [NUM_CORES-1:0] txActive,
  output logic [NUM_CORES-1:0] busy,
  output logic [NUM_CORES-1:0] logOverflow
);

  ubank_pkg::strobe_t strobe;
  logic [CORE_W-1:0]  logCore;
  logic [SLOT_W-1:0]  logSlot;

  ubank_ctrl #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .LOG_DEPTH(LOG_DEPTH)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqCore(reqCore), .reqAddr(reqAddr),
    .txBegin(txBegin), .txCommit(txCommit), .txAbort(txAbort),
    .reqGrant(reqGrant), .txActive(txActive), .busy(busy), .logOverflow(logOverflow),
    .strobe(strobe), .logCore(logCore), .logSlot(logSlot)
  );

  ubank_dp #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOG_DEPTH(LOG_DEPTH)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .logCore(logCore), .logSlot(logSlot),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdData(rdData)
  );

endmodule

// File: tb/sim_ubank_top.sv
`timescale 1ns/1ps
module sim_ubank_top;
  localparam int NC = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int LD = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqCore = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqGrant;
  logic [DW-1:0] rdData;
  logic [NC-1:0] txBegin = '0, txCommit = '0, txAbort = '0;
  logic [NC-1:0] txActive, busy, logOverflow;

  always #2 clk = ~clk;

  ubank_top #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW), .LOG_DEPTH(LD)) u0 (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqCore(reqCore), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqGrant(reqGrant), .rdData(rdData),
    .txBegin(txBegin), .txCommit(txCommit), .txAbort(txAbort),
    .txActive(txActive), .busy(busy), .logOverflow(logOverflow)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  // Reference model
  int mMem [DEPTH];
  bit mOpen [NC];
  bit mOvf [NC];
  bit mMap [NC][DEPTH];
  int mCnt [NC];
  int mLogA [NC][LD];
  int mLogD [NC][LD];

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void clearLog(int c);
    mCnt[c] = 0;
    for (int a = 0; a < DEPTH; a++) mMap[c][a] = 0;
  endfunction

  function automatic int expGrant(int c, bit wr, int a);
    if (wr && mOpen[c] && (mOvf[c] || (!mMap[c][a] && mCnt[c] == LD))) return 0;
    return 1;
  endfunction

  function automatic void modelWrite(int c, int a, int d);
    if (mOpen[c] && !mMap[c][a]) begin
      mLogA[c][mCnt[c]] = a;
      mLogD[c][mCnt[c]] = mMem[a];
      mMap[c][a] = 1;
      mCnt[c]++;
    end
    mMem[a] = d;
  endfunction

  function automatic int modelAbort(int c);
    int n;
    if (!mOpen[c]) return 0;
    n = (mCnt[c] > 0) ? mCnt[c] + 1 : 0;
    for (int i = mCnt[c] - 1; i >= 0; i--) mMem[mLogA[c][i]] = mLogD[c][i];
    mOpen[c] = 0;
    mOvf[c] = 0;
    clearLog(c);
    return n;
  endfunction

  function automatic void modelCommit(int c);
    if (mOpen[c] && !mOvf[c]) begin
      mOpen[c] = 0;
      clearLog(c);
    end
  endfunction

  task automatic access(int c, bit wr, int a, int d, string tag);
    int g;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqCore = c[1:0];
    reqAddr = a[AW-1:0]; reqWdata = d[DW-1:0];
    #1;
    g = expGrant(c, wr, a);
    chk({tag, " grant"}, int'(reqGrant), g);
    @(posedge clk); #1;
    reqValid = 1'b0; reqWrite = 1'b0;
    if (g && wr) modelWrite(c, a, d);
    if (!g && wr) mOvf[c] = 1;
    if (g && !wr) chk({tag, " R9 read data"}, int'(rdData), mMem[a]);
    chk({tag, " R7 overflow flag"}, int'(logOverflow[c]), int'(mOvf[c]));
  endtask

  task automatic waitBusy(int c, int expN, string tag);
    int n = 0;
    while (busy[c] && n < 100) begin
      n++;
      @(posedge clk); #1;
    end
    chk({tag, " R5 busy cycles"}, n, expN);
  endtask

  // kind: 0 begin, 1 commit, 2 abort
  task automatic strobeOp(int kind, int c, string tag);
    int expN = 0;
    @(negedge clk);
    if (kind == 0) txBegin[c] = 1'b1;
    else if (kind == 1) txCommit[c] = 1'b1;
    else txAbort[c] = 1'b1;
    @(posedge clk); #1;
    txBegin = '0; txCommit = '0; txAbort = '0;
    if (kind == 0) begin
      if (!mOpen[c]) mOpen[c] = 1;
    end else if (kind == 1) begin
      modelCommit(c);
    end else begin
      expN = modelAbort(c);
    end
    chk({tag, " R4 active"}, int'(txActive[c]), int'(mOpen[c]));
    if (kind == 2) waitBusy(c, expN, tag);
  endtask

  initial begin
    int n0, n1, r, c, a, d;
    void'($urandom(32'd715));
    for (int i = 0; i < DEPTH; i++) mMem[i] = 0;
    for (int k = 0; k < NC; k++) begin
      mOpen[k] = 0; mOvf[k] = 0; clearLog(k);
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 txActive", int'(txActive), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 overflow", int'(logOverflow), 0);
    access(2, 0, 5, 0, "R1 read after reset");

    // R2 write outside a transaction is not logged
    access(0, 1, 3, 16'h1111, "R2 bypass write");
    strobeOp(2, 0, "R2 abort with no tx");
    access(0, 0, 3, 0, "R2 word kept");

    // R3 only first write logged, R5 restore
    strobeOp(0, 1, "R3 begin");
    access(1, 1, 2, 16'h0A01, "R3 write a");
    access(1, 1, 2, 16'h0A02, "R3 rewrite a");
    access(1, 1, 2, 16'h0A03, "R3 rewrite a again");
    access(1, 1, 4, 16'h0B01, "R3 write b");
    strobeOp(2, 1, "R3 abort two entries");
    access(1, 0, 2, 0, "R5 restored a");
    access(1, 0, 4, 0, "R5 restored b");

    // R7 overflow
    strobeOp(0, 2, "R7 begin");
    for (int i = 8; i < 12; i++) access(2, 1, i, 16'h2000 + i, "R7 fill");
    access(2, 1, 12, 16'h2222, "R7 refused new addr");
    access(2, 1, 8, 16'h2223, "R7 refused logged addr");
    access(2, 0, 9, 0, "R7 read while overflowed");
    strobeOp(1, 2, "R7 commit ignored");
    strobeOp(2, 2, "R7 abort clears");
    for (int i = 8; i < 13; i++) access(2, 0, i, 0, "R7 restored");

    // R4 commit keeps data
    strobeOp(0, 3, "R4 begin");
    access(3, 1, 5, 16'h0055, "R4 write");
    strobeOp(1, 3, "R4 commit");
    access(3, 0, 5, 0, "R4 data kept");
    strobeOp(2, 3, "R4 abort after commit");
    access(3, 0, 5, 0, "R4 data still kept");

    // R8 begin while open ignored, abort beats commit
    strobeOp(0, 3, "R8 begin");
    access(3, 1, 6, 16'h0066, "R8 write");
    strobeOp(0, 3, "R8 second begin");
    @(negedge clk); txCommit[3] = 1'b1; txAbort[3] = 1'b1;
    @(posedge clk); #1; txCommit = '0; txAbort = '0;
    n0 = modelAbort(3);
    chk("R8 abort wins active", int'(txActive[3]), 0);
    waitBusy(3, n0, "R8 abort wins");
    access(3, 0, 6, 0, "R8 restored");

    // R6 stall rules
    strobeOp(0, 1, "R6 begin");
    access(1, 1, 13, 16'h0007, "R6 write c");
    access(1, 1, 14, 16'h0008, "R6 write d");
    @(negedge clk);
    txAbort[1] = 1'b1;
    reqValid = 1'b1; reqWrite = 1'b1; reqCore = 2'd1; reqAddr = 4'd15; reqWdata = 16'h7777;
    #1; chk("R6 same-cycle abort grant", int'(reqGrant), 0);
    @(posedge clk); #1; txAbort = '0; reqValid = 1'b0; reqWrite = 1'b0;
    n0 = modelAbort(1);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqCore = 2'd0; reqAddr = 4'd3;
    #1; chk("R6 grant during restore", int'(reqGrant), 0);
    @(posedge clk); #1; reqValid = 1'b0;
    waitBusy(1, n0 - 1, "R6 remaining");
    access(0, 0, 13, 0, "R6 restored c");
    access(0, 0, 15, 0, "R6 refused write absent");

    // R10 simultaneous aborts, lowest core first
    strobeOp(0, 0, "R10 begin0");
    strobeOp(0, 1, "R10 begin1");
    access(0, 1, 1, 16'h0101, "R10 core0 w1");
    access(0, 1, 2, 16'h0102, "R10 core0 w2");
    access(1, 1, 7, 16'h0107, "R10 core1 w7");
    @(negedge clk); txAbort[0] = 1'b1; txAbort[1] = 1'b1;
    @(posedge clk); #1; txAbort = '0;
    void'(modelAbort(0)); void'(modelAbort(1));
    n0 = 0; n1 = 0;
    while (busy != '0 && n1 < 100) begin
      if (busy[0]) n0++;
      if (busy[1]) n1++;
      @(posedge clk); #1;
    end
    chk("R10 core0 busy", n0, 3);
    chk("R10 core1 busy", n1, 5);
    access(1, 0, 1, 0, "R10 restored 1");
    access(1, 0, 7, 0, "R10 restored 7");

    // Random traffic
    for (int it = 0; it < 2000; it++) begin
      r = $urandom % 100; c = $urandom % NC; a = $urandom % 10; d = $urandom % 65536;
      if (r < 45)      access(c, 1, a, d, "R3 random write");
      else if (r < 70) access(c, 0, a, 0, "R9 random read");
      else if (r < 82) strobeOp(0, c, "R8 random begin");
      else if (r < 90) strobeOp(1, c, "R4 random commit");
      else             strobeOp(2, c, "R5 random abort");
    end
    for (int k = 0; k < NC; k++) strobeOp(2, k, "R5 final abort");
    for (int i = 0; i < DEPTH; i++) access(0, 0, i, 0, "R10 final contents");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

endmodule